// File: doc/BRIEF.md
# AND-NOT Execute Unit

This block runs one scalar AND-NOT operation per request. It holds a small general register file. On each start pulse it reads two source registers, inverts the first source, ANDs it with the second source and writes the result to a destination register. The register indices arrive already decoded. Alongside them come the processor mode, the vector-length bit and the width bit. From these the block picks a 32-bit or a 64-bit operand size and decides whether the request is legal.

One clock after the start pulse the block raises `done` for one cycle. At the same time it shows the registered result and the fault bit. The status flags are held in a register inside the block and are always visible on `flags`. A faulting request writes nothing and leaves the flags as they were. A separate load port lets neighbouring logic fill registers and the flags word. The bench uses that port to set up operands.

Top module: `andn_exec_unit`

## Requirements
- R1: Synchronous active-high reset clears every register, the flags word, `done`, `fault` and `result` to zero.
- R2: A legal request computes (NOT src1) AND src2 and writes it to register `dst_idx`. `src1_idx` selects the inverted source and `src2_idx` the plain one. `done` is high exactly one cycle after `start`, with `result` equal to the value written.
- R3: In 64-bit mode (`mode`=2'b11) `wide`=1 selects a 64-bit operand size and `wide`=0 selects 32 bits. A 32-bit result has bits 63:32 zero, both in `result` and in the destination register.
- R4: Mode encoding is 00 real, 01 virtual-8086, 10 protected/compatibility, 11 64-bit. In mode 10 the operand size is 32 bits whatever `wide` is.
- R5: SF (flags bit 4) takes bit 31 of the result at 32-bit size and bit 63 at 64-bit size.
- R6: ZF (flags bit 3) is 1 exactly when the result at the active size is zero.
- R7: A legal request clears CF (bit 0) and OF (bit 5) and leaves PF (bit 1) and AF (bit 2) unchanged.
- R8: `vlen`=1 raises `fault`, drives `result` to zero, and suppresses both the register write and the flag update.
- R9: Modes 00 and 01 raise `fault` with the same suppression as R8.
- R10: Outside 64-bit mode, any of the three indices at 8 or above raises `fault` with the same suppression as R8. In 64-bit mode indices 0 to 15 are legal.
- R11: `ld_en` writes `ld_data` to register `ld_idx`, and `ld_flags_en` loads `ld_flags` into the flags word, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request valid for one cycle |
| mode | input | 2 | Processor mode (R4 encoding) |
| dst_idx | input | 4 | Destination register index |
| src1_idx | input | 4 | Index of the source that is inverted |
| src2_idx | input | 4 | Index of the plain source |
| vlen | input | 1 | Vector-length bit, must be 0 |
| wide | input | 1 | Width bit, selects 64-bit size in 64-bit mode |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register load index |
| ld_data | input | 64 | Register load value |
| ld_flags_en | input | 1 | Flags load strobe |
| ld_flags | input | 6 | Flags load value |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Invalid-opcode indication, valid with done |
| result | output | 64 | Registered result |
| flags | output | 6 | Flags word {OF,SF,ZF,AF,PF,CF} |

## Verification
A wrong size select shows as nonzero upper result bits, or as an SF taken from the wrong bit. Both appear on the `done` cycle of a 32-bit request, one clock after `start`. A write or flag update leaking through a fault does not show on that cycle. It shows when the destination is read back through a later request, so every fault scenario ends with a readback request a few cycles later. Corrupted PF or AF shows on `flags` right after the first legal request that follows a flags load.

// File: rtl/andn_pkg.sv
package andn_pkg;
   typedef enum logic [1:0] {
      MODE_REAL = 2'b00,
      MODE_V86  = 2'b01,
      MODE_PROT = 2'b10,
      MODE_LONG = 2'b11
   } cpu_mode_e;

   localparam int NFLAGS = 6;
   localparam int FL_CF  = 0;
   localparam int FL_PF  = 1;
   localparam int FL_AF  = 2;
   localparam int FL_ZF  = 3;
   localparam int FL_SF  = 4;
   localparam int FL_OF  = 5;
endpackage

// File: rtl/andn_regfile.sv
module andn_regfile #(
   parameter int XLEN  = 64,
   parameter int NREGS = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ex_we,
   input  logic [$clog2(NREGS)-1:0] ex_idx,
   input  logic [XLEN-1:0]          ex_data,
   input  logic                     ld_we,
   input  logic [$clog2(NREGS)-1:0] ld_idx,
   input  logic [XLEN-1:0]          ld_data,
   input  logic [$clog2(NREGS)-1:0] rd_a_idx,
   output logic [XLEN-1:0]          rd_a,
   input  logic [$clog2(NREGS)-1:0] rd_b_idx,
   output logic [XLEN-1:0]          rd_b
);
   localparam int IW = $clog2(NREGS);

   if (NREGS < 2 || (1 << IW) != NREGS) begin : g_bad_depth
      $error("andn_regfile: NREGS must be a power of two >= 2");
   end

   logic [XLEN-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs[g] <= '0;
         else if (ex_we && ex_idx == IW'(g))
            regs[g] <= ex_data;
         else if (ld_we && ld_idx == IW'(g))
            regs[g] <= ld_data;
      end
   end

   assign rd_a = regs[rd_a_idx];
   assign rd_b = regs[rd_b_idx];

   // R11: the bench never aims both write ports at one register in a cycle
   p_single_writer_r11: assert property (@(posedge clk) disable iff (rst)
      !(ex_we && ld_we && ex_idx == ld_idx));
endmodule

// File: rtl/andn_legal.sv
module andn_legal
   import andn_pkg::*;
#(
   parameter int NREGS       = 16,
   parameter int LEGACY_REGS = 8
) (
   input  logic [1:0]               mode,
   input  logic                     vlen,
   input  logic                     wide,
   input  logic [$clog2(NREGS)-1:0] dst_idx,
   input  logic [$clog2(NREGS)-1:0] src1_idx,
   input  logic [$clog2(NREGS)-1:0] src2_idx,
   output logic                     bad,
   output logic                     use_wide
);
   localparam int IW = $clog2(NREGS);

   if (LEGACY_REGS < 1 || LEGACY_REGS > NREGS) begin : g_bad_legacy
      $error("andn_legal: LEGACY_REGS out of range");
   end

   logic long_mode;
   logic legacy_mode;
   logic idx_high;

   assign long_mode   = (mode == MODE_LONG);
   assign legacy_mode = (mode == MODE_REAL) || (mode == MODE_V86);

   if (LEGACY_REGS == NREGS) begin : g_no_idx_limit
      assign idx_high = 1'b0;
   end else begin : g_idx_limit
      assign idx_high = (dst_idx  >= IW'(LEGACY_REGS)) ||
                        (src1_idx >= IW'(LEGACY_REGS)) ||
                        (src2_idx >= IW'(LEGACY_REGS));
   end

   assign bad      = vlen || legacy_mode || (!long_mode && idx_high);
   assign use_wide = long_mode && wide;
endmodule

// File: rtl/andn_alu.sv
module andn_alu #(
   parameter int XLEN   = 64,
   parameter int NARROW = 32
) (
   input  logic [XLEN-1:0] inv_src,
   input  logic [XLEN-1:0] pass_src,
   input  logic            use_wide,
   output logic [XLEN-1:0] res,
   output logic            sign,
   output logic            zero
);
   if (NARROW < 1 || NARROW >= XLEN) begin : g_bad_narrow
      $error("andn_alu: NARROW must be below XLEN");
   end

   logic [XLEN-1:0]   full;
   logic [NARROW-1:0] low;

   assign full = ~inv_src & pass_src;
   assign low  = full[NARROW-1:0];

   always_comb begin
      if (use_wide) begin
         res  = full;
         sign = full[XLEN-1];
         zero = (full == '0);
      end else begin
         res  = {{(XLEN-NARROW){1'b0}}, low};
         sign = low[NARROW-1];
         zero = (low == '0);
      end
   end
endmodule

// File: rtl/andn_exec_unit.sv
module andn_exec_unit
   import andn_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int NARROW      = 32,
   parameter int NREGS       = 16,
   parameter int LEGACY_REGS = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [1:0]               mode,
   input  logic [$clog2(NREGS)-1:0] dst_idx,
   input  logic [$clog2(NREGS)-1:0] src1_idx,
   input  logic [$clog2(NREGS)-1:0] src2_idx,
   input  logic                     vlen,
   input  logic                     wide,
   input  logic                     ld_en,
   input  logic [$clog2(NREGS)-1:0] ld_idx,
   input  logic [XLEN-1:0]          ld_data,
   input  logic                     ld_flags_en,
   input  logic [5:0]               ld_flags,
   output logic                     done,
   output logic                     fault,
   output logic [XLEN-1:0]          result,
   output logic [5:0]               flags
);
   if (NFLAGS != 6) begin : g_bad_flags
      $error("andn_exec_unit: flags word width mismatch");
   end

   logic [XLEN-1:0] rd_inv, rd_pass, alu_res;
   logic            alu_sign, alu_zero;
   logic            bad_c, wide_c, commit;

   andn_legal #(.NREGS(NREGS), .LEGACY_REGS(LEGACY_REGS)) u_legal (
      .mode(mode), .vlen(vlen), .wide(wide),
      .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx),
      .bad(bad_c), .use_wide(wide_c)
   );

   andn_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
      .clk(clk), .rst(rst),
      .ex_we(commit), .ex_idx(dst_idx), .ex_data(alu_res),
      .ld_we(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .rd_a_idx(src1_idx), .rd_a(rd_inv),
      .rd_b_idx(src2_idx), .rd_b(rd_pass)
   );

   andn_alu #(.XLEN(XLEN), .NARROW(NARROW)) u_alu (
      .inv_src(rd_inv), .pass_src(rd_pass), .use_wide(wide_c),
      .res(alu_res), .sign(alu_sign), .zero(alu_zero)
   );

   assign commit = start && !bad_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         done   <= 1'b0;
         fault  <= 1'b0;
         result <= '0;
      end else begin
         done   <= start;
         fault  <= start && bad_c;
         result <= commit ? alu_res : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flags <= '0;
      end else if (commit) begin
         flags[FL_CF] <= 1'b0;
         flags[FL_OF] <= 1'b0;
         flags[FL_SF] <= alu_sign;
         flags[FL_ZF] <= alu_zero;
      end else if (ld_flags_en) begin
         flags <= ld_flags;
      end
   end

   p_done_after_start_r2: assert property (@(posedge clk) disable iff (rst)
      start |=> done);
   p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
      !start |=> !done);
   p_narrow_zext_r3: assert property (@(posedge clk) disable iff (rst)
      (start && mode != MODE_LONG && !vlen) |=> (result[XLEN-1:NARROW] == '0));
   p_ofcf_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (done && !fault) |-> (!flags[FL_CF] && !flags[FL_OF]));
   p_afpf_kept_r7: assert property (@(posedge clk) disable iff (rst)
      (start && !ld_flags_en) |=> (flags[FL_AF] == $past(flags[FL_AF]) &&
                                   flags[FL_PF] == $past(flags[FL_PF])));
   p_sz_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
      (done && !fault) |-> !(flags[FL_SF] && flags[FL_ZF]));
   p_vlen_fault_r8: assert property (@(posedge clk) disable iff (rst)
      (start && vlen) |=> (fault && result == '0));
   p_fault_keeps_flags_r8: assert property (@(posedge clk) disable iff (rst)
      (start && vlen && !ld_flags_en) |=> $stable(flags));
   p_legacy_mode_fault_r9: assert property (@(posedge clk) disable iff (rst)
      (start && (mode == MODE_REAL || mode == MODE_V86)) |=> fault);
endmodule

// File: tb/sim_andn_exec_unit.sv
module sim_andn_exec_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b11;
   logic [3:0]  dst_idx = '0, src1_idx = '0, src2_idx = '0;
   logic        vlen = 1'b0, wide = 1'b0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_idx = '0;
   logic [63:0] ld_data = '0;
   logic        ld_flags_en = 1'b0;
   logic [5:0]  ld_flags = '0;
   logic        done, fault;
   logic [63:0] result;
   logic [5:0]  flags;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   andn_exec_unit u0 (
      .clk(clk), .rst(rst), .start(start), .mode(mode),
      .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx),
      .vlen(vlen), .wide(wide),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .ld_flags_en(ld_flags_en), .ld_flags(ld_flags),
      .done(done), .fault(fault), .result(result), .flags(flags)
   );

   // Model registers written by the bench; reg 14 stays zero, reg 13 is scratch
   logic [63:0] mdl [16];

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_andn(logic [63:0] a, logic [63:0] b, bit w64);
      logic [63:0] f;
      f = ~a & b;
      return w64 ? f : {32'h0, f[31:0]};
   endfunction

   task automatic exec(logic [1:0] md, bit w, bit l, logic [3:0] d, logic [3:0] s1, logic [3:0] s2);
      @(negedge clk);
      start = 1; mode = md; wide = w; vlen = l;
      dst_idx = d; src1_idx = s1; src2_idx = s2;
      @(negedge clk);
      start = 0; vlen = 0;
   endtask

   task automatic load(logic [3:0] i, logic [63:0] v);
      @(negedge clk);
      ld_en = 1; ld_idx = i; ld_data = v;
      @(negedge clk);
      ld_en = 0;
      mdl[i] = v;
   endtask

   task automatic load_flags(logic [5:0] v);
      @(negedge clk);
      ld_flags_en = 1; ld_flags = v;
      @(negedge clk);
      ld_flags_en = 0;
   endtask

   task automatic readback(logic [3:0] i, output logic [63:0] v);
      exec(2'b11, 1, 0, 4'd13, 4'd14, i);
      v = result;
   endtask

   task automatic t_reset;
      logic [63:0] v;
      chk("R1 done", {63'h0, done}, 64'h0);
      chk("R1 fault", {63'h0, fault}, 64'h0);
      chk("R1 result", result, 64'h0);
      chk("R1 flags", {58'h0, flags}, 64'h0);
      readback(4'd3, v);
      chk("R1 reg3", v, 64'h0);
   endtask

   task automatic t_load;
      logic [63:0] v;
      load(4'd1, 64'h0F0F_0000_FFFF_0000);
      load(4'd2, 64'hFFFF_FFFF_0000_FFFF);
      load(4'd3, 64'h0);
      load(4'd4, 64'h1234_5678_9ABC_DEF0);
      load(4'd6, 64'hFFFF_FFFF_FFFF_FFFF);
      load(4'd7, 64'h0000_0000_8000_0000);
      load(4'd8, 64'hABCD_0000_0000_0000);
      load(4'd9, 64'h5555_AAAA_5555_AAAA);
      load(4'd11, 64'hFEDC_BA98_7654_3210);
      readback(4'd11, v);
      chk("R11 load reg11", v, 64'hFEDC_BA98_7654_3210);
      load_flags(6'h2A);
      chk("R11 flags load", {58'h0, flags}, 64'h2A);
   endtask

   task automatic t_basic64;
      logic [63:0] e, v;
      e = ref_andn(mdl[1], mdl[2], 1);
      exec(2'b11, 1, 0, 4'd5, 4'd1, 4'd2);
      chk("R2 done", {63'h0, done}, 64'h1);
      chk("R2 fault", {63'h0, fault}, 64'h0);
      chk("R2 result", result, e);
      chk("R5 sf 64", {63'h0, flags[4]}, {63'h0, e[63]});
      mdl[5] = e;
      @(negedge clk);
      chk("R2 done one cycle", {63'h0, done}, 64'h0);
      readback(4'd5, v);
      chk("R2 written", v, e);
      // operand order: swapping sources differs
      e = ref_andn(mdl[2], mdl[4], 1);
      exec(2'b11, 1, 0, 4'd10, 4'd2, 4'd4);
      chk("R2 order", result, e);
   endtask

   task automatic t_narrow;
      logic [63:0] e, v;
      e = ref_andn(mdl[1], mdl[2], 0);
      exec(2'b11, 0, 0, 4'd6, 4'd1, 4'd2);
      chk("R3 narrow result", result, e);
      readback(4'd6, v);
      chk("R3 zero extend reg", v, e);
      e = ref_andn(mdl[3], mdl[6], 1);
      exec(2'b11, 1, 0, 4'd12, 4'd3, 4'd4);
      chk("R3 wide result", result, ref_andn(mdl[3], mdl[4], 1));
   endtask

   task automatic t_compat;
      exec(2'b10, 1, 0, 4'd5, 4'd3, 4'd4);
      chk("R4 w ignored fault", {63'h0, fault}, 64'h0);
      chk("R4 w ignored size", result, ref_andn(mdl[3], mdl[4], 0));
      exec(2'b10, 1, 0, 4'd5, 4'd3, 4'd7);
      chk("R5 sf compat bit31", {63'h0, flags[4]}, 64'h1);
   endtask

   task automatic t_sign;
      exec(2'b11, 0, 0, 4'd10, 4'd3, 4'd7);
      chk("R5 sf bit31 narrow", {63'h0, flags[4]}, 64'h1);
      exec(2'b11, 1, 0, 4'd10, 4'd3, 4'd7);
      chk("R5 sf bit63 wide", {63'h0, flags[4]}, 64'h0);
   endtask

   task automatic t_zero;
      exec(2'b11, 1, 0, 4'd10, 4'd4, 4'd4);
      chk("R6 zf self", {63'h0, flags[3]}, 64'h1);
      exec(2'b11, 0, 0, 4'd10, 4'd3, 4'd8);
      chk("R6 zf narrow upper only", {63'h0, flags[3]}, 64'h1);
      exec(2'b11, 1, 0, 4'd10, 4'd3, 4'd8);
      chk("R6 zf wide", {63'h0, flags[3]}, 64'h0);
   endtask

   task automatic t_flags_kept;
      load_flags(6'h3F);
      exec(2'b11, 1, 0, 4'd10, 4'd3, 4'd4);
      chk("R7 cf of clear", {62'h0, flags[5], flags[0]}, 64'h0);
      chk("R7 af pf kept", {62'h0, flags[2], flags[1]}, 64'h3);
      load_flags(6'h00);
      exec(2'b11, 1, 0, 4'd10, 4'd3, 4'd4);
      chk("R7 af pf kept clear", {62'h0, flags[2], flags[1]}, 64'h0);
   endtask

   task automatic t_faults;
      logic [63:0] v;
      load_flags(6'h15);
      exec(2'b11, 1, 1, 4'd9, 4'd3, 4'd4);
      chk("R8 vlen fault", {63'h0, fault}, 64'h1);
      chk("R8 result zero", result, 64'h0);
      chk("R8 flags kept", {58'h0, flags}, 64'h15);
      readback(4'd9, v);
      chk("R8 no write", v, mdl[9]);

      load_flags(6'h15);
      exec(2'b00, 1, 0, 4'd9, 4'd3, 4'd4);
      chk("R9 real fault", {63'h0, fault}, 64'h1);
      chk("R9 real flags kept", {58'h0, flags}, 64'h15);
      exec(2'b01, 0, 0, 4'd9, 4'd3, 4'd4);
      chk("R9 v86 fault", {63'h0, fault}, 64'h1);
      chk("R9 v86 result", result, 64'h0);
      readback(4'd9, v);
      chk("R9 no write", v, mdl[9]);

      exec(2'b10, 0, 0, 4'd9, 4'd3, 4'd4);
      chk("R10 dst high fault", {63'h0, fault}, 64'h1);
      exec(2'b10, 0, 0, 4'd5, 4'd8, 4'd4);
      chk("R10 src1 high fault", {63'h0, fault}, 64'h1);
      exec(2'b10, 0, 0, 4'd5, 4'd3, 4'd11);
      chk("R10 src2 high fault", {63'h0, fault}, 64'h1);
      readback(4'd9, v);
      chk("R10 no write", v, mdl[9]);
      exec(2'b11, 1, 0, 4'd15, 4'd8, 4'd11);
      chk("R10 long high ok", {63'h0, fault}, 64'h0);
      chk("R10 long high result", result, ref_andn(mdl[8], mdl[11], 1));
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_load();
      t_basic64();
      t_narrow();
      t_compat();
      t_sign();
      t_zero();
      t_flags_kept();
      t_faults();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule